// File: doc/BRIEF.md
# Wait-State Wake-Up and Vector Controller

This block looks after the low-power wait state of a small 8-bit processor core. When the core issues a wait strobe, the block stops the clock that drives the core's address and data buses. The free-running clock `clk`, which the peripherals use, keeps running. On the edge that enters the wait state, the block also sends two one-cycle strobes to the core's register file. One clears the interrupt mask bit. The other sets the enable bit for the external interrupt pin. It touches no other register bit.

While in the wait state, the block watches its wake sources:

- the raw active-low interrupt pin, which is synchronized and edge-detected,
- four level requests from the on-chip peripherals,
- a watchdog timeout,
- the external reset pin.

When a source is seen, the block returns to the run state and restarts the core clock glitch-free on the following cycle. It emits a one-cycle wake pulse, a flag that says whether the wake is a reset or an interrupt, and the 16-bit address of the vector high byte. The low byte sits at that address plus one.

The vector addresses are:

| Wake source | Vector (high byte) |
|---|---|
| Any reset source | `VEC_BASE+0xE` |
| Interrupt pin | `VEC_BASE+0xA` |
| Programmable timer | `VEC_BASE+0x6` |
| Serial bus | `VEC_BASE+0x4` |
| Analog comparator | `VEC_BASE+0x2` |
| Core timer | `VEC_BASE+0x0` |

With the default base these are $1FFE, $1FFA, $1FF6, $1FF4, $1FF2 and $1FF0.

Top module: `wwk_wait_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes to the run state. After that edge `waiting`, `wake_pulse`, `clr_imask`, `set_irq_en` and `wake_is_reset` are 0, `wake_vec` holds `VEC_BASE+0xE`, and `cpu_clk` follows `clk`.
- R2: A `wait_req` sampled high in the run state raises `waiting` after that edge. `clr_imask` and `set_irq_en` are each high for exactly that one cycle.
- R3: From the second rising edge of `clk` after wait entry until the wake, `cpu_clk` stays low.
- R4: A high-to-low transition on `irq_pin_n` passes through two synchronizer flops and an edge detector, then sets a pending flag. In the wait state, a pin fall placed before edge k gives a wake at edge k+3 with vector `VEC_BASE+0xA`. A rising transition sets nothing.
- R5: In the wait state, each peripheral request wakes the core at the next edge with its own vector: `ptmr_req` gives +0x6, `sbus_req` gives +0x4, `anlg_req` gives +0x2 and `ctmr_req` gives +0x0. The flag `wake_is_reset` is 0.
- R6: In the wait state, `wdog_timeout` high or `ext_reset_n` low wakes at the next edge with `wake_is_reset`=1 and vector `VEC_BASE+0xE`. This holds whatever interrupts are also present.
- R7: When several interrupts are present together, the winner is chosen in this order: interrupt pin, then programmable timer, then serial bus, then analog comparator, then core timer.
- R8: `wake_pulse` lasts one cycle and `waiting` is 0 in that cycle. `cpu_clk` gives its first rising edge at the next `clk` rising edge.
- R9: The pin pending flag stays set until `vec_ack` is sampled high. While it is set, every later wait entry wakes at the edge after entry with the pin vector.
- R10: In the run state, wake sources cause no wake pulse and leave `wake_vec` unchanged. `wait_req` in the wait state is ignored, and the block stays in run until the next `wait_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock, also used by peripherals |
| rst_n | input | 1 | Synchronous active-low reset of this block |
| wait_req | input | 1 | One-cycle wait strobe from the core |
| irq_pin_n | input | 1 | Raw asynchronous active-low interrupt pin |
| ptmr_req | input | 1 | Programmable timer interrupt request |
| sbus_req | input | 1 | Serial bus transfer-complete request |
| anlg_req | input | 1 | Analog comparator request |
| ctmr_req | input | 1 | Core timer overflow / periodic request |
| wdog_timeout | input | 1 | Watchdog timeout (reset source) |
| ext_reset_n | input | 1 | External reset pin level, low = reset source |
| vec_ack | input | 1 | Core acknowledges the pin vector fetch |
| cpu_clk | output | 1 | Gated core bus clock |
| waiting | output | 1 | Block is in the wait state |
| clr_imask | output | 1 | Strobe: clear interrupt mask bit |
| set_irq_en | output | 1 | Strobe: set external interrupt enable bit |
| wake_pulse | output | 1 | One-cycle wake indication |
| wake_is_reset | output | 1 | Last wake was a reset source |
| wake_vec | output | 16 | Address of the vector high byte |

## Verification
The assertions assume these inputs are synchronous to `clk`:

- the peripheral requests,
- the watchdog timeout,
- the external reset level,
- the wait strobe.

Only the interrupt pin may be asynchronous.

The bench changes every input a quarter period after a rising edge. It holds each wake source as a level until the wake has been observed, then releases the source and pulses `vec_ack`. Random rounds draw source sets from a seeded generator. When a round includes a pin fall, the pending flag is made to settle before the wait is entered.

// File: rtl/wwk_pkg.sv
// Package for the wait/wake controller: state type, source indices,
// and the vector offsets added to the vector base.
package wwk_pkg;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_WAIT = 1'b1
    } wwk_state_e;

    // Interrupt source indices; a lower index has higher priority.
    localparam int SRC_NUM  = 5;
    localparam int SRC_IRQ  = 0;
    localparam int SRC_PTMR = 1;
    localparam int SRC_SBUS = 2;
    localparam int SRC_ANLG = 3;
    localparam int SRC_CTMR = 4;

    localparam logic [3:0] OFS_RESET = 4'hE;

    // Offset of each interrupt source's vector from the base.
    function automatic logic [3:0] src_ofs(input int idx);
        case (idx)
            SRC_IRQ:  src_ofs = 4'hA;
            SRC_PTMR: src_ofs = 4'h6;
            SRC_SBUS: src_ofs = 4'h4;
            SRC_ANLG: src_ofs = 4'h2;
            default:  src_ofs = 4'h0;
        endcase
    endfunction

endpackage

// File: rtl/wwk_irq_sync.sv
// Interrupt pin front end.
// Brings the raw active-low pin through STAGES flops, detects a falling
// edge, and keeps a pending flag set until acknowledged.
// Assumes STAGES >= 2. A set and a clear in the same cycle leave it set.
module wwk_irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic ack,
    output logic pend
);
    logic [STAGES:0] sync_q;
    logic            fall;

    // Shift the pin through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[STAGES-1:0], pin_n};
    end

    assign fall = sync_q[STAGES] & ~sync_q[STAGES-1];

    // Pending flag: set on a falling edge, cleared by ack.
    always_ff @(posedge clk) begin
        if (!rst_n)    pend <= 1'b0;
        else if (fall) pend <= 1'b1;
        else if (ack)  pend <= 1'b0;
    end
endmodule

// File: rtl/wwk_arbiter.sv
// Combinational wake arbiter.
// A reset source wins over every interrupt. Among interrupts, the lowest
// index wins. Outputs the vector high-byte address and the reset flag.
module wwk_arbiter
    import wwk_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] VEC_BASE = 16'h1FF0
) (
    input  logic               rst_src,
    input  logic [SRC_NUM-1:0] int_req,
    output logic               any_src,
    output logic               is_reset,
    output logic [ADDR_W-1:0]  vec
);
    // Priority select: walk from the lowest priority up, so the last hit wins.
    always_comb begin
        vec      = VEC_BASE + ADDR_W'(OFS_RESET);
        is_reset = rst_src;
        any_src  = rst_src | (|int_req);
        if (!rst_src) begin
            for (int i = SRC_NUM - 1; i >= 0; i--) begin
                if (int_req[i]) vec = VEC_BASE + ADDR_W'(src_ofs(i));
            end
        end
    end
endmodule

// File: rtl/wwk_clk_gate.sv
// Glitch-free clock gate.
// The enable passes a latch that is transparent only while clk is low,
// so the gated clock never shows a shortened pulse.
module wwk_clk_gate (
    input  logic clk,
    input  logic en,
    output logic gclk
);
    logic en_lat;

    // Capture the enable during the low phase only.
    always_latch begin
        if (!clk) en_lat = en;
    end

    assign gclk = clk & en_lat;
endmodule

// File: rtl/wwk_wait_ctrl.sv
// Wait-state controller, top level.
// A wait strobe in run enters the wait state: it stops cpu_clk and sends
// one-cycle mask-clear and irq-enable strobes. In wait, the first wake
// source seen returns the block to run, pulses wake_pulse, and latches the
// vector and the reset flag.
// Assumes: every input except irq_pin_n is synchronous to clk.
module wwk_wait_ctrl
    import wwk_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] VEC_BASE    = 16'h1FF0,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wait_req,
    input  logic              irq_pin_n,
    input  logic              ptmr_req,
    input  logic              sbus_req,
    input  logic              anlg_req,
    input  logic              ctmr_req,
    input  logic              wdog_timeout,
    input  logic              ext_reset_n,
    input  logic              vec_ack,
    output logic              cpu_clk,
    output logic              waiting,
    output logic              clr_imask,
    output logic              set_irq_en,
    output logic              wake_pulse,
    output logic              wake_is_reset,
    output logic [ADDR_W-1:0] wake_vec
);
    wwk_state_e          state_q;
    logic                cpu_en_q;
    logic                irq_pend;
    logic [SRC_NUM-1:0]  int_req;
    logic                any_src;
    logic                sel_reset;
    logic [ADDR_W-1:0]   sel_vec;

    wwk_irq_sync #(.STAGES(SYNC_STAGES)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (irq_pin_n),
        .ack   (vec_ack),
        .pend  (irq_pend)
    );

    // Gather the interrupt requests in priority order.
    always_comb begin
        int_req           = '0;
        int_req[SRC_IRQ]  = irq_pend;
        int_req[SRC_PTMR] = ptmr_req;
        int_req[SRC_SBUS] = sbus_req;
        int_req[SRC_ANLG] = anlg_req;
        int_req[SRC_CTMR] = ctmr_req;
    end

    wwk_arbiter #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_arb (
        .rst_src  (wdog_timeout | ~ext_reset_n),
        .int_req  (int_req),
        .any_src  (any_src),
        .is_reset (sel_reset),
        .vec      (sel_vec)
    );

    // Run/wait sequencing, entry strobes and wake capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_RUN;
            cpu_en_q      <= 1'b1;
            clr_imask     <= 1'b0;
            set_irq_en    <= 1'b0;
            wake_pulse    <= 1'b0;
            wake_is_reset <= 1'b0;
            wake_vec      <= VEC_BASE + ADDR_W'(OFS_RESET);
        end else begin
            clr_imask  <= 1'b0;
            set_irq_en <= 1'b0;
            wake_pulse <= 1'b0;
            case (state_q)
                ST_RUN: begin
                    if (wait_req) begin
                        state_q    <= ST_WAIT;
                        cpu_en_q   <= 1'b0;
                        clr_imask  <= 1'b1;
                        set_irq_en <= 1'b1;
                    end
                end
                default: begin
                    if (any_src) begin
                        state_q       <= ST_RUN;
                        cpu_en_q      <= 1'b1;
                        wake_pulse    <= 1'b1;
                        wake_is_reset <= sel_reset;
                        wake_vec      <= sel_vec;
                    end
                end
            endcase
        end
    end

    assign waiting = (state_q == ST_WAIT);

    wwk_clk_gate u_gate (
        .clk  (clk),
        .en   (cpu_en_q),
        .gclk (cpu_clk)
    );
endmodule

// File: rtl/wwk_wait_ctrl_chk.sv
// Property checker for wwk_wait_ctrl, attached with bind.
// Assumes the same synchronous inputs as the design.
module wwk_wait_ctrl_chk #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] VEC_BASE = 16'h1FF0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wait_req,
    input logic              ptmr_req,
    input logic              wdog_timeout,
    input logic              ext_reset_n,
    input logic              waiting,
    input logic              clr_imask,
    input logic              set_irq_en,
    input logic              wake_pulse,
    input logic              wake_is_reset,
    input logic [ADDR_W-1:0] wake_vec
);
    assert_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!waiting && wait_req) |=> (waiting && clr_imask && set_irq_en));

    assert_strobe_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_imask |=> !clr_imask);

    assert_ptmr_wakes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && ptmr_req) |=> wake_pulse);

    assert_reset_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && (wdog_timeout || !ext_reset_n)) |=> (wake_pulse && wake_is_reset));

    assert_reset_vec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_pulse && wake_is_reset) |-> (wake_vec == VEC_BASE + ADDR_W'(4'hE)));

    assert_wake_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);

    assert_wake_runs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> !waiting);

    assert_run_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !waiting |=> !wake_pulse);

    assert_vec_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_pulse |-> $stable(wake_vec));
endmodule

bind wwk_wait_ctrl wwk_wait_ctrl_chk #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wait_req      (wait_req),
    .ptmr_req      (ptmr_req),
    .wdog_timeout  (wdog_timeout),
    .ext_reset_n   (ext_reset_n),
    .waiting       (waiting),
    .clr_imask     (clr_imask),
    .set_irq_en    (set_irq_en),
    .wake_pulse    (wake_pulse),
    .wake_is_reset (wake_is_reset),
    .wake_vec      (wake_vec)
);

// File: tb/wwk_wait_ctrl_tb.sv
// Self-checking bench for wwk_wait_ctrl.
// Inputs change 5 ns after a rising edge. Outputs are sampled there too.
module wwk_wait_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wait_req = 1'b0, irq_pin_n = 1'b1;
    logic        ptmr_req = 1'b0, sbus_req = 1'b0, anlg_req = 1'b0, ctmr_req = 1'b0;
    logic        wdog_timeout = 1'b0, ext_reset_n = 1'b1, vec_ack = 1'b0;
    logic        cpu_clk, waiting, clr_imask, set_irq_en, wake_pulse, wake_is_reset;
    logic [15:0] wake_vec;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    wwk_wait_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .irq_pin_n(irq_pin_n),
        .ptmr_req(ptmr_req), .sbus_req(sbus_req), .anlg_req(anlg_req),
        .ctmr_req(ctmr_req), .wdog_timeout(wdog_timeout), .ext_reset_n(ext_reset_n),
        .vec_ack(vec_ack), .cpu_clk(cpu_clk), .waiting(waiting),
        .clr_imask(clr_imask), .set_irq_en(set_irq_en), .wake_pulse(wake_pulse),
        .wake_is_reset(wake_is_reset), .wake_vec(wake_vec)
    );

    // Advance one clock and land in the high phase, away from the edge.
    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected {is_reset, vector} from the requirements.
    function automatic logic [16:0] exp_wake(input bit rs, input bit irq, input bit p,
                                             input bit s, input bit a, input bit c);
        if (rs)  return {1'b1, 16'h1FFE};
        if (irq) return {1'b0, 16'h1FFA};
        if (p)   return {1'b0, 16'h1FF6};
        if (s)   return {1'b0, 16'h1FF4};
        if (a)   return {1'b0, 16'h1FF2};
        return {1'b0, 16'h1FF0};
    endfunction

    task automatic clear_srcs();
        ptmr_req = 0; sbus_req = 0; anlg_req = 0; ctmr_req = 0;
        wdog_timeout = 0; ext_reset_n = 1;
    endtask

    task automatic enter_wait(input string req);
        wait_req = 1'b1;
        tick();
        wait_req = 1'b0;
        chk(req, "waiting after entry", waiting, 1);
    endtask

    task automatic ack();
        vec_ack = 1'b1;
        tick();
        vec_ack = 1'b0;
    endtask

    // Make the pin pending flag settle while in run.
    task automatic pin_fall_settle();
        irq_pin_n = 1'b0;
        repeat (4) tick();
        irq_pin_n = 1'b1;
        repeat (3) tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [16:0] e;
        int unsigned seed;
        seed = 32'd12345;
        void'($urandom(seed));

        // R1: reset state.
        repeat (3) tick();
        chk("R1", "waiting", waiting, 0);
        chk("R1", "wake_pulse", wake_pulse, 0);
        chk("R1", "clr_imask", clr_imask, 0);
        chk("R1", "wake_vec", wake_vec, 16'h1FFE);
        chk("R1", "wake_is_reset", wake_is_reset, 0);
        chk("R1", "cpu_clk high phase", cpu_clk, 1);
        rst_n = 1'b1;
        tick();

        // R2 and R3: entry strobes and gated clock.
        wait_req = 1'b1;
        tick();
        wait_req = 1'b0;
        chk("R2", "waiting", waiting, 1);
        chk("R2", "clr_imask", clr_imask, 1);
        chk("R2", "set_irq_en", set_irq_en, 1);
        tick();
        chk("R2", "clr_imask second cycle", clr_imask, 0);
        chk("R2", "set_irq_en second cycle", set_irq_en, 0);
        chk("R3", "cpu_clk gated", cpu_clk, 0);
        // R10: a wait strobe while waiting is ignored.
        wait_req = 1'b1;
        tick();
        wait_req = 1'b0;
        chk("R10", "wait strobe in wait", clr_imask, 0);
        chk("R3", "cpu_clk still gated", cpu_clk, 0);

        // R4: pin fall latency is four ticks from the drive point.
        irq_pin_n = 1'b0;
        tick(); tick(); tick();
        chk("R4", "no wake before edge k+3", waiting, 1);
        tick();
        chk("R4", "wake pulse", wake_pulse, 1);
        chk("R4", "pin vector", wake_vec, 16'h1FFA);
        chk("R8", "waiting low on wake", waiting, 0);
        chk("R8", "cpu_clk not yet", cpu_clk, 0);
        tick();
        chk("R8", "pulse single", wake_pulse, 0);
        chk("R8", "cpu_clk restarted", cpu_clk, 1);

        // R9: without an ack, the pending flag causes an immediate wake.
        irq_pin_n = 1'b1;
        repeat (3) tick();
        enter_wait("R9");
        tick();
        chk("R9", "re-wake from pending", wake_pulse, 1);
        chk("R9", "vector", wake_vec, 16'h1FFA);
        ack();
        enter_wait("R9");
        repeat (3) tick();
        chk("R9", "stays waiting after ack", waiting, 1);
        ctmr_req = 1'b1;
        tick();
        chk("R5", "core timer vector", wake_vec, 16'h1FF0);
        ctmr_req = 1'b0;

        // R4: a rising pin edge sets nothing.
        irq_pin_n = 1'b0;
        repeat (4) tick();
        ack();
        irq_pin_n = 1'b1;
        repeat (4) tick();
        enter_wait("R4");
        repeat (3) tick();
        chk("R4", "rising edge no wake", waiting, 1);
        wdog_timeout = 1'b1;
        ptmr_req = 1'b1;
        tick();
        // R6: reset source beats a timer request.
        chk("R6", "wdog reset flag", wake_is_reset, 1);
        chk("R6", "wdog vector", wake_vec, 16'h1FFE);
        clear_srcs();

        // R10: sources in run do nothing.
        sbus_req = 1'b1;
        ext_reset_n = 1'b0;
        repeat (3) tick();
        chk("R10", "no pulse in run", wake_pulse, 0);
        chk("R10", "vector held in run", wake_vec, 16'h1FFE);
        chk("R10", "still run", waiting, 0);
        clear_srcs();

        // R6: external reset pin alone.
        enter_wait("R6");
        ext_reset_n = 1'b0;
        tick();
        chk("R6", "ext reset flag", wake_is_reset, 1);
        ext_reset_n = 1'b1;

        // R5 and R7: random source sets, checked against the priority model.
        for (int it = 0; it < 300; it++) begin
            bit use_irq, rs, p, s, a, c;
            logic [31:0] r;
            r = $urandom();
            use_irq = (r[2:0] == 3'd0);
            rs = (r[7:4] == 4'd0);
            p = r[8]; s = r[9]; a = r[10]; c = r[11];
            if (!(use_irq | rs | p | s | a | c)) c = 1'b1;
            if (use_irq) pin_fall_settle();
            enter_wait("R7");
            ptmr_req = p; sbus_req = s; anlg_req = a; ctmr_req = c;
            wdog_timeout = rs & r[12];
            ext_reset_n = ~(rs & ~r[12]);
            tick();
            e = exp_wake(rs, use_irq, p, s, a, c);
            chk("R7", "random wake pulse", wake_pulse, 1);
            chk("R7", "random vector", wake_vec, e[15:0]);
            chk("R5", "random reset flag", wake_is_reset, e[16]);
            clear_srcs();
            ack();
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule